// File: doc/BRIEF.md
# Posted-Write Register Bridge for a Dual-Clock Timer

This block is the register front end of a timer whose counting logic runs on a slow functional clock that is unrelated to the host bus clock. It decodes the host register map. Writes to the timer's working registers cross into the functional domain through a toggle handshake with one request and one acknowledge per register. Each of these registers has a flag in a readable pending-status word. The flag is set when the host write is accepted and clears once the functional domain has taken the value and its acknowledge has come back through a two-flop synchroniser.

In posted mode, which is the mode after reset, a write finishes on the bus at once. Software then reads the status word and waits for the flag to clear before it touches that register again. Clearing the posted-enable bit in the interface control register changes the behaviour: writes to working registers hold the bus with `h_ready` low until the transfer has been acknowledged.

A few registers are not posted: the wake-up enable, the capture value and the interface control register. The live counter and the capture value are copied back into the host domain by a free-running snapshot handshake. Host reads of those two addresses return the latest copy. The functional side gets every working register as a parallel word, together with a one-cycle update strobe per register.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset the pending-status word (0x34) reads 0, the interface control register (0x40) reads 0x4 (posted mode on), wake-up enable (0x20) reads 0, and all functional register copies and update strobes are 0.
- R2: Working registers and their pending bits are: control 0x24 bit 0, counter 0x28 bit 1, load 0x2C bit 2, trigger 0x30 bit 3, match 0x38 bit 4, and tick-correction register k (k = 0..4) at 0x44+4k bit 5+k. In posted mode a write to any of them completes with `h_ready` high in the first cycle.
- R3: A pending bit reads 1 from the cycle after its write is accepted, and stays 1 until the acknowledge for that transfer is back in the host domain; then it reads 0. Several bits can be set at the same time.
- R4: Each accepted write updates the matching slice of `f_regs` (slice i = bits 32i+31..32i) with one single-cycle `f_upd[i]` pulse. The update happens within 3 rising `f_clk` edges after the accepting host edge, and `f_regs` never changes without a strobe.
- R5: In posted mode, a write to a register whose pending bit is still set is dropped. The functional copy and the readback keep the earlier value.
- R6: With bit 2 of 0x40 cleared, a write to a working register holds `h_ready` low until its transfer is acknowledged, and its pending bit is clear when the write completes. If the bit was already set by an earlier write, the new write waits for it to clear before it is launched.
- R7: Reads of working registers return the last accepted write value. The exception is the counter address 0x28, which returns the resynchronised `f_count`. The capture address 0x3C returns the resynchronised `f_capture`, and writes to it have no effect.
- R8: Wake-up enable (0x20) is a full-width read/write register. Interface control (0x40) stores only bit 2, and its other bits read 0. Writes to both complete without a stall in either mode and set no pending bit.
- R9: Unmapped addresses read 0. Writes to them cause no update strobe and no pending bit.
- R10: Reads never stall: `h_ready` is high for every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| h_clk | input | 1 | Host bus clock |
| h_sel | input | 1 | Bus access valid, held until h_ready |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Byte address |
| h_wdata | input | DW | Write data |
| h_rdata | output | DW | Read data |
| h_ready | output | 1 | Access completes on the edge where this is high |
| wake_en | output | DW | Wake-up enable register value (host domain) |
| f_clk | input | 1 | Timer functional clock |
| f_count | input | DW | Live counter value from the timer |
| f_capture | input | DW | Captured value from the timer |
| f_regs | output | (5+NTICK)*DW | Functional copies of the working registers |
| f_upd | output | 5+NTICK | One-cycle update strobe per working register |

## Verification
Directed writes to every working register isolate each pending bit and its strobe. They tell a wrong bit position or a wrong slice apart from a missing handshake. Back-to-back writes to one register separate drop-while-pending from overwrite. Writes to three registers at once show that the flags are independent.

Non-posted writes, including one issued while an older flag is still set, distinguish a real stall-until-acknowledge from an early completion. A seeded random mix of working and direct register writes checks functional copies and readback against a bench model. Changing `f_count` and `f_capture` shows that readback tracks the functional domain and ignores host writes.

// File: rtl/posted_reg_bridge.sv
module posted_reg_bridge #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int NTICK     = 5,
  parameter int TICK_BASE = 'h44
) (
  input  logic                    rst_n,
  input  logic                    h_clk,
  input  logic                    h_sel,
  input  logic                    h_wr,
  input  logic [AW-1:0]           h_addr,
  input  logic [DW-1:0]           h_wdata,
  output logic [DW-1:0]           h_rdata,
  output logic                    h_ready,
  output logic [DW-1:0]           wake_en,
  input  logic                    f_clk,
  input  logic [DW-1:0]           f_count,
  input  logic [DW-1:0]           f_capture,
  output logic [(5+NTICK)*DW-1:0] f_regs,
  output logic [4+NTICK:0]        f_upd
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NP = 5 + NTICK;
  localparam logic [AW-1:0] A_WAKE = AW'('h20);
  localparam logic [AW-1:0] A_CNT  = AW'('h28);
  localparam logic [AW-1:0] A_PEND = AW'('h34);
  localparam logic [AW-1:0] A_CAP  = AW'('h3C);
  localparam logic [AW-1:0] A_IFC  = AW'('h40);

  // host side state
  logic [NP-1:0] req_h, ack_s1, ack_s2, pend, hit, launch;
  logic [DW-1:0] shadow [NP];
  logic          ipost, busy;
  logic [DW-1:0] cnt_h, cap_h;
  logic          snap_s1, snap_s2, snap_seen;

  // functional side state
  logic [NP-1:0] req_s1, req_s2, ack_f;
  logic [DW-1:0] freg [NP];
  logic [DW-1:0] snap_cnt, snap_cap;
  logic          snap_tg, back_s1, back_s2;

  always_comb begin
    hit = '0;
    case (h_addr)
      AW'('h24): hit[0] = 1'b1;
      AW'('h28): hit[1] = 1'b1;
      AW'('h2C): hit[2] = 1'b1;
      AW'('h30): hit[3] = 1'b1;
      AW'('h38): hit[4] = 1'b1;
      default: ;
    endcase
    for (int k = 0; k < NTICK; k++)
      if (h_addr == AW'(TICK_BASE + 4*k)) hit[5+k] = 1'b1;
  end

  wire wr_any   = h_sel && h_wr;
  wire wr_post  = wr_any && (|hit);
  wire sel_pend = |(hit & pend);
  wire np_wr    = wr_post && !ipost;

  assign pend    = req_h ^ ack_s2;
  assign h_ready = !(np_wr && (!busy || sel_pend));
  assign launch  = (wr_any && (ipost || !busy)) ? (hit & ~pend) : '0;

  always_ff @(posedge h_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (np_wr && !sel_pend) begin
      busy <= !busy;
    end
  end

  always_ff @(posedge h_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_h   <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      wake_en <= '0;
      ipost   <= 1'b1;
    end else begin
      ack_s1 <= ack_f;
      ack_s2 <= ack_s1;
      req_h  <= req_h ^ launch;
      if (wr_any && h_addr == A_WAKE) wake_en <= h_wdata;
      if (wr_any && h_addr == A_IFC)  ipost   <= h_wdata[2];
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_post
    always_ff @(posedge h_clk or negedge rst_n) begin
      if (!rst_n)         shadow[i] <= '0;
      else if (launch[i]) shadow[i] <= h_wdata;
    end

    always_ff @(posedge f_clk or negedge rst_n) begin
      if (!rst_n) begin
        freg[i]  <= '0;
        f_upd[i] <= 1'b0;
      end else begin
        f_upd[i] <= req_s2[i] ^ ack_f[i];
        if (req_s2[i] ^ ack_f[i]) freg[i] <= shadow[i];
      end
    end

    assign f_regs[i*DW +: DW] = freg[i];
  end

  always_ff @(posedge f_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= '0;
      req_s2 <= '0;
      ack_f  <= '0;
    end else begin
      req_s1 <= req_h;
      req_s2 <= req_s1;
      ack_f  <= req_s2;
    end
  end

  // counter/capture snapshot loop: functional side captures, host copies
  always_ff @(posedge f_clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cnt <= '0;
      snap_cap <= '0;
      snap_tg  <= 1'b0;
      back_s1  <= 1'b0;
      back_s2  <= 1'b0;
    end else begin
      back_s1 <= snap_seen;
      back_s2 <= back_s1;
      if (snap_tg == back_s2) begin
        snap_cnt <= f_count;
        snap_cap <= f_capture;
        snap_tg  <= !snap_tg;
      end
    end
  end

  always_ff @(posedge h_clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_s1   <= 1'b0;
      snap_s2   <= 1'b0;
      snap_seen <= 1'b0;
      cnt_h     <= '0;
      cap_h     <= '0;
    end else begin
      snap_s1 <= snap_tg;
      snap_s2 <= snap_s1;
      if (snap_s2 != snap_seen) begin
        cnt_h     <= snap_cnt;
        cap_h     <= snap_cap;
        snap_seen <= snap_s2;
      end
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_sel && !h_wr) begin
      if (h_addr == A_WAKE)      h_rdata = wake_en;
      else if (h_addr == A_PEND) h_rdata = DW'(pend);
      else if (h_addr == A_CAP)  h_rdata = cap_h;
      else if (h_addr == A_IFC)  h_rdata = DW'({ipost, 2'b00});
      else if (h_addr == A_CNT)  h_rdata = cnt_h;
      else
        for (int k = 0; k < NP; k++)
          if (hit[k]) h_rdata = shadow[k];
    end
  end

  p_ready_posted_r2: assert property (@(posedge h_clk) disable iff (!rst_n)
    (h_sel && ipost) |-> h_ready);

  p_pend_set_r3: assert property (@(posedge h_clk) disable iff (!rst_n)
    (|launch) |=> ((pend & $past(launch)) == $past(launch)));

  p_pend_clear_r3: assert property (@(posedge h_clk) disable iff (!rst_n)
    ((~pend & $past(pend)) != '0) |-> (ack_s2 != $past(ack_s2)));

  p_upd_strobe_r4: assert property (@(posedge f_clk) disable iff (!rst_n)
    !$stable(f_regs) |-> (|f_upd));

  p_np_wait_r6: assert property (@(posedge h_clk) disable iff (!rst_n)
    (np_wr && h_ready) |-> (busy && !sel_pend));

  p_read_ready_r10: assert property (@(posedge h_clk) disable iff (!rst_n)
    (h_sel && !h_wr) |-> h_ready);
endmodule

// File: tb/posted_reg_bridge_bench.sv
module posted_reg_bridge_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam int NP = 10;

  logic rst_n = 1'b0, h_clk = 1'b0, f_clk = 1'b0;
  logic h_sel = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0, f_count = '0, f_capture = '0;
  logic [31:0] h_rdata, wake_en;
  logic        h_ready;
  logic [NP*32-1:0] f_regs;
  logic [NP-1:0]    f_upd;

  int n_tests = 0, n_fail = 0;
  int upd_cnt [NP];
  logic [31:0] model [NP];

  posted_reg_bridge u_posted_reg_bridge (
    .rst_n(rst_n), .h_clk(h_clk), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .wake_en(wake_en),
    .f_clk(f_clk), .f_count(f_count), .f_capture(f_capture),
    .f_regs(f_regs), .f_upd(f_upd));

  always #10 h_clk = ~h_clk;
  always #37 f_clk = ~f_clk;

  initial for (int i = 0; i < NP; i++) upd_cnt[i] = 0;
  always @(negedge f_clk)
    for (int i = 0; i < NP; i++) if (f_upd[i]) upd_cnt[i]++;

  function automatic logic [7:0] addr_of(int i);
    case (i)
      0: return 8'h24;
      1: return 8'h28;
      2: return 8'h2C;
      3: return 8'h30;
      4: return 8'h38;
      default: return 8'(8'h44 + 4*(i-5));
    endcase
  endfunction

  function automatic logic [31:0] fslice(int i);
    return f_regs[i*32 +: 32];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int st);
    st = 0;
    @(negedge h_clk); h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d; #1;
    while (!h_ready) begin st++; @(negedge h_clk); #1; end
    @(posedge h_clk); #1; h_sel = 0; h_wr = 0;
  endtask

  int rd_stalls = 0;
  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge h_clk); h_sel = 1; h_wr = 0; h_addr = a; #1;
    d = h_rdata;
    if (!h_ready) rd_stalls++;
    @(posedge h_clk); #1; h_sel = 0;
  endtask

  task automatic wait_clear(int i);
    logic [31:0] v;
    int n = 0;
    do begin bus_rd(8'h34, v); n++; end while (v[i] && n < 500);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, d, d2;
    int st, n, base;
    int unsigned seed;
    seed = $urandom(32'd1357);
    for (int i = 0; i < NP; i++) model[i] = '0;
    repeat (5) @(negedge h_clk);
    rst_n = 1;
    repeat (3) @(negedge h_clk);

    // R1 reset state
    bus_rd(8'h34, v); chk("R1 pend", v, 0);
    bus_rd(8'h40, v); chk("R1 ifc", v, 32'h4);
    bus_rd(8'h20, v); chk("R1 wake", v, 0);
    chk("R1 fregs", (f_regs == '0 && f_upd == '0) ? 1 : 0, 1);

    // R2 R3 R4 R7: each working register
    for (int i = 0; i < NP; i++) begin
      d = $urandom;
      base = upd_cnt[i];
      bus_wr(addr_of(i), d, st);
      chk("R2 posted no stall", st, 0);
      bus_rd(8'h34, v); chk("R3 pend bit", v, 32'(1 << i));
      wait_clear(i);
      bus_rd(8'h34, v); chk("R3 pend cleared", v, 0);
      chk("R4 fcopy", fslice(i), d);
      chk("R4 one strobe", upd_cnt[i] - base, 1);
      model[i] = d;
      if (i != 1) begin bus_rd(addr_of(i), v); chk("R7 readback", v, d); end
    end

    // R4 latency in f_clk edges
    d = $urandom;
    bus_wr(8'h24, d, st);
    n = 0;
    while (fslice(0) !== d && n < 10) begin @(posedge f_clk); #1; n++; end
    chk("R4 latency<=3", (n >= 1 && n <= 3) ? 1 : 0, 1);
    wait_clear(0); model[0] = d;

    // R5 drop while pending
    d = $urandom; d2 = ~d;
    base = upd_cnt[2];
    bus_wr(8'h2C, d, st);
    bus_wr(8'h2C, d2, st);
    chk("R5 no stall", st, 0);
    wait_clear(2);
    repeat (20) @(negedge h_clk);
    chk("R5 fcopy keeps first", fslice(2), d);
    chk("R5 single strobe", upd_cnt[2] - base, 1);
    bus_rd(8'h2C, v); chk("R5 readback keeps first", v, d);
    model[2] = d;

    // R3 several pending together
    bus_wr(addr_of(4), 32'h11, st);
    bus_wr(addr_of(6), 32'h22, st);
    bus_wr(addr_of(9), 32'h33, st);
    bus_rd(8'h34, v); chk("R3 multi pend", v, 32'h250);
    wait_clear(4); wait_clear(6); wait_clear(9);
    model[4] = 32'h11; model[6] = 32'h22; model[9] = 32'h33;
    chk("R4 multi fcopy", (fslice(4) == 32'h11 && fslice(6) == 32'h22 && fslice(9) == 32'h33) ? 1 : 0, 1);

    // random mix (R4, R7, R8)
    for (int it = 0; it < 30; it++) begin
      int i;
      i = int'($urandom % NP);
      d = $urandom;
      if ($urandom % 4 == 0) begin
        bus_wr(8'h20, d, st);
        bus_rd(8'h20, v); chk("R8 wake rw", v, d);
      end else begin
        bus_wr(addr_of(i), d, st);
        wait_clear(i);
        model[i] = d;
        chk("R4 random fcopy", fslice(i), model[i]);
        if (i != 1) begin bus_rd(addr_of(i), v); chk("R7 random readback", v, model[i]); end
      end
    end

    // R7 counter and capture resync
    for (int k = 0; k < 2; k++) begin
      f_count = $urandom; f_capture = $urandom;
      repeat (40) @(negedge h_clk);
      bus_rd(8'h28, v); chk("R7 counter read", v, f_count);
      bus_rd(8'h3C, v); chk("R7 capture read", v, f_capture);
    end
    bus_wr(8'h3C, ~f_capture, st);
    bus_rd(8'h3C, v); chk("R7 capture write ignored", v, f_capture);

    // R8 direct registers
    bus_wr(8'h40, 32'hFFFF_FFFF, st);
    chk("R8 ifc no stall", st, 0);
    bus_rd(8'h40, v); chk("R8 ifc only bit2", v, 32'h4);
    bus_rd(8'h34, v); chk("R8 no pend", v, 0);

    // R6 non-posted mode
    bus_wr(8'h40, 32'h0, st);
    bus_rd(8'h40, v); chk("R6 ifc cleared", v, 0);
    d = $urandom;
    bus_wr(8'h2C, d, st);
    chk("R6 stalled", (st > 0) ? 1 : 0, 1);
    bus_rd(8'h34, v); chk("R6 pend clear at done", v, 0);
    chk("R6 fcopy at done", fslice(2), d);
    d = $urandom;
    bus_wr(8'h20, d, st);
    chk("R8 wake no stall nonposted", st, 0);
    // older pending write, then non-posted write waits
    bus_wr(8'h40, 32'h4, st);
    base = upd_cnt[4];
    d = $urandom; d2 = $urandom;
    bus_wr(8'h38, d, st);
    bus_wr(8'h40, 32'h0, st);
    bus_wr(8'h38, d2, st);
    chk("R6 waited", (st > 0) ? 1 : 0, 1);
    bus_rd(8'h34, v); chk("R6 pend clear", v, 0);
    chk("R6 second value delivered", fslice(4), d2);
    chk("R6 two strobes", upd_cnt[4] - base, 2);
    bus_wr(8'h40, 32'h4, st);

    // R9 unmapped
    for (int i = 0; i < NP; i++) base += 0;
    n = 0;
    for (int i = 0; i < NP; i++) n += upd_cnt[i];
    bus_wr(8'h70, 32'hDEAD_BEEF, st);
    bus_rd(8'h34, v); chk("R9 no pend", v, 0);
    repeat (30) @(negedge h_clk);
    bus_rd(8'h70, v); chk("R9 reads zero", v, 0);
    st = 0;
    for (int i = 0; i < NP; i++) st += upd_cnt[i];
    chk("R9 no strobe", st - n, 0);

    // R10 reads never stalled
    chk("R10 read stalls", rd_stalls, 0);

    finish_run();
  end
endmodule